// File: doc/BRIEF.md
# Multi-Mode Phase Accumulator Controller

This block is the numerically controlled oscillator front end of a direct digital synthesizer. Each clock it adds a frequency tuning word to a wide phase accumulator. It then adds a phase offset to the top of the accumulator and registers the result. The output is a truncated phase word for a downstream phase-to-amplitude stage. The synthesized frequency is the tuning word times the clock rate divided by two to the accumulator width. Any frequency from dc up to half the clock rate is possible.

Two tuning words and two phase offsets are presented as static inputs. A 3-bit mode field and a single data pin decide which ones are used. In frequency-shift-keying mode the pin picks between the two tuning words. In binary phase-shift-keying mode it picks between the two offsets. In every other mode the pin is ignored and the first word of each pair is used. A frequency switch never clears the accumulator, so the phase stays continuous across keying. Swept modes are served by another block. Here their codes behave like single tone.

Top module: `nco_mode_ctrl`

## Requirements
- R1: While the active-low reset `rst_n` is low, and after its release while both selected words are zero, `phase_o` is 0.
- R2: On every clock the accumulator grows by the selected tuning word modulo 2^48. `phase_o` equals accumulator bits [47:32] plus the selected 14-bit offset shifted left by 2, modulo 2^16. Inputs present before clock edge m reach the accumulator at edge m and reach `phase_o` at edge m+1.
- R3: With `mode_i` = 3'b001, `sel_i` low selects `ftw_a_i` and `sel_i` high selects `ftw_b_i`.
- R4: With `mode_i` = 3'b100, `sel_i` low selects `poff_a_i` and `sel_i` high selects `poff_b_i`. The frequency comes from `ftw_a_i`.
- R5: A change of the selected tuning word never resets the accumulator. The next phase continues from the last accumulated value.
- R6: In every mode other than 3'b001, `ftw_b_i` has no effect.
- R7: In every mode other than 3'b100, `poff_b_i` has no effect.
- R8: Codes 3'b000, 3'b010, 3'b011 and 3'b101 to 3'b111 ignore `sel_i` and use `ftw_a_i` and `poff_a_i`.
- R9: The accumulator wraps modulo 2^48. A word of 2^48-2^32 makes `phase_o` fall by exactly 1 per clock.
- R10: The offset addition wraps modulo 2^16. With an accumulator top of 0x0008 and an offset of 14'h3FFF, the output is 0x0004.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode code |
| sel_i | input | 1 | Shared keying data pin |
| ftw_a_i | input | 48 | First frequency tuning word |
| ftw_b_i | input | 48 | Second frequency tuning word |
| poff_a_i | input | 14 | First phase offset |
| poff_b_i | input | 14 | Second phase offset |
| phase_o | output | 16 | Truncated, offset phase word |

## Verification
The bench uses the default widths: a 48-bit accumulator, 14-bit offsets and a 16-bit output. Tuning words that are multiples of 2^32, 2^35, 2^40 and 2^41 move the observed top bits by known amounts each clock. This lets keying latency, phase continuity and accumulator wrap be checked as exact per-cycle differences. The full-width offset 14'h3FFF, next to a small accumulator top, reaches the output wrap in two cycles.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int ACC_W_DEF = 48;
    localparam int OFF_W_DEF = 14;
    localparam int OUT_W_DEF = 16;
    localparam int MODE_W    = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_TONE  = 3'b000,
        MODE_FSK   = 3'b001,
        MODE_RAMP  = 3'b010,
        MODE_SWEEP = 3'b011,
        MODE_BPSK  = 3'b100
    } nco_mode_e;
endpackage

// File: rtl/nco_word_sel.sv
module nco_word_sel
    import nco_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int OFF_W = OFF_W_DEF
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              sel_i,
    input  logic [ACC_W-1:0]  ftw_a_i,
    input  logic [ACC_W-1:0]  ftw_b_i,
    input  logic [OFF_W-1:0]  off_a_i,
    input  logic [OFF_W-1:0]  off_b_i,
    output logic [ACC_W-1:0]  ftw_o,
    output logic [OFF_W-1:0]  off_o
);
    typedef struct packed {
        logic use_ftw_b;
        logic use_off_b;
    } route_t;

    route_t route;

    // The data pin is only meaningful in the two keying modes.
    always_comb begin
        route = '0;
        case (mode_i)
            MODE_FSK:  route.use_ftw_b = sel_i;
            MODE_BPSK: route.use_off_b = sel_i;
            default:   route = '0;
        endcase
    end

    always_comb begin
        ftw_o = route.use_ftw_b ? ftw_b_i : ftw_a_i;
        off_o = route.use_off_b ? off_b_i : off_a_i;
    end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int OFF_W = OFF_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [ACC_W-1:0] acc_o,
    output logic [OFF_W-1:0] off_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [OFF_W-1:0] off;
    } acc_state_t;

    acc_state_t state_d, state_q;

    // The offset is staged alongside the sum so both reach the output together.
    always_comb begin
        state_d     = state_q;
        state_d.acc = state_q.acc + ftw_i;
        state_d.off = off_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o = state_q.acc;
    assign off_o = state_q.off;
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out
    import nco_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int OUT_W = OUT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [OUT_W-1:0] phase_o
);
    typedef struct packed {
        logic [OUT_W-1:0] phase;
    } out_state_t;

    out_state_t       state_d, state_q;
    logic [OUT_W-1:0] acc_top;
    logic [OUT_W-1:0] off_ext;

    assign acc_top = acc_i[ACC_W-1 -: OUT_W];

    // Align the offset with the most significant bits of the output word.
    generate
        if (OUT_W > OFF_W) begin : g_off_pad
            assign off_ext = {off_i, {(OUT_W-OFF_W){1'b0}}};
        end else if (OUT_W == OFF_W) begin : g_off_same
            assign off_ext = off_i;
        end else begin : g_off_cut
            assign off_ext = off_i[OFF_W-1 -: OUT_W];
        end
    endgenerate

    always_comb begin
        state_d       = state_q;
        state_d.phase = acc_top + off_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o = state_q.phase;
endmodule

// File: rtl/nco_mode_ctrl.sv
module nco_mode_ctrl
    import nco_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int OUT_W = OUT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              sel_i,
    input  logic [ACC_W-1:0]  ftw_a_i,
    input  logic [ACC_W-1:0]  ftw_b_i,
    input  logic [OFF_W-1:0]  poff_a_i,
    input  logic [OFF_W-1:0]  poff_b_i,
    output logic [OUT_W-1:0]  phase_o
);
    logic [ACC_W-1:0] ftw_sel;
    logic [OFF_W-1:0] off_sel;
    logic [ACC_W-1:0] acc_w;
    logic [OFF_W-1:0] off_w;

    nco_word_sel #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_sel (
        .mode_i  (mode_i),
        .sel_i   (sel_i),
        .ftw_a_i (ftw_a_i),
        .ftw_b_i (ftw_b_i),
        .off_a_i (poff_a_i),
        .off_b_i (poff_b_i),
        .ftw_o   (ftw_sel),
        .off_o   (off_sel)
    );

    nco_phase_acc #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .ftw_i (ftw_sel),
        .off_i (off_sel),
        .acc_o (acc_w),
        .off_o (off_w)
    );

    nco_phase_out #(.ACC_W(ACC_W), .OFF_W(OFF_W), .OUT_W(OUT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_i   (acc_w),
        .off_i   (off_w),
        .phase_o (phase_o)
    );
endmodule

// File: rtl/nco_mode_ctrl_chk.sv
module nco_mode_ctrl_chk
    import nco_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int OUT_W = OUT_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic              sel_i,
    input logic [ACC_W-1:0]  ftw_a_i,
    input logic [ACC_W-1:0]  ftw_b_i,
    input logic [OFF_W-1:0]  poff_a_i,
    input logic [OFF_W-1:0]  poff_b_i,
    input logic [ACC_W-1:0]  acc_i,
    input logic [OUT_W-1:0]  phase_o
);
    localparam int SH = (OUT_W > OFF_W) ? OUT_W - OFF_W : 0;

    // Cycles since reset release, saturating; output checks need two.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_i == '0 && phase_o == '0));

    assert_fsk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FSK && !sel_i) |=> acc_i == $past(acc_i) + $past(ftw_a_i));

    assert_fsk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FSK && sel_i) |=> acc_i == $past(acc_i) + $past(ftw_b_i));

    // Covers R8 as well: every non-FSK code steps by the first word.
    assert_other_freq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_FSK) |=> acc_i == $past(acc_i) + $past(ftw_a_i));

    assert_bpsk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(mode_i == MODE_BPSK && sel_i, 2)) |->
        phase_o == OUT_W'($past(acc_i[ACC_W-1 -: OUT_W]) + (OUT_W'($past(poff_b_i, 2)) << SH)));

    assert_other_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !$past(mode_i == MODE_BPSK && sel_i, 2)) |->
        phase_o == OUT_W'($past(acc_i[ACC_W-1 -: OUT_W]) + (OUT_W'($past(poff_a_i, 2)) << SH)));
endmodule

bind nco_mode_ctrl nco_mode_ctrl_chk #(
    .ACC_W(ACC_W),
    .OFF_W(OFF_W),
    .OUT_W(OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .sel_i    (sel_i),
    .ftw_a_i  (ftw_a_i),
    .ftw_b_i  (ftw_b_i),
    .poff_a_i (poff_a_i),
    .poff_b_i (poff_b_i),
    .acc_i    (acc_w),
    .phase_o  (phase_o)
);

// File: tb/nco_mode_ctrl_bench.sv
module nco_mode_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'b000;
    logic        sel_i = 1'b0;
    logic [47:0] ftw_a_i = '0;
    logic [47:0] ftw_b_i = '0;
    logic [13:0] poff_a_i = '0;
    logic [13:0] poff_b_i = '0;
    logic [15:0] phase_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nco_mode_ctrl u_nco_mode_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .sel_i    (sel_i),
        .ftw_a_i  (ftw_a_i),
        .ftw_b_i  (ftw_b_i),
        .poff_a_i (poff_a_i),
        .poff_b_i (poff_b_i),
        .phase_o  (phase_o)
    );

    // Reference model written from R2, R3, R4 and R8.
    logic [47:0] m_acc;
    logic [13:0] m_off;
    logic [15:0] m_ph;

    function automatic logic [47:0] pick_ftw();
        return (mode_i == 3'b001 && sel_i) ? ftw_b_i : ftw_a_i;
    endfunction

    function automatic logic [13:0] pick_off();
        return (mode_i == 3'b100 && sel_i) ? poff_b_i : poff_a_i;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc <= '0;
            m_off <= '0;
            m_ph  <= '0;
        end else begin
            m_acc <= m_acc + pick_ftw();
            m_off <= pick_off();
            m_ph  <= m_acc[47:32] + {m_off, 2'b00};
        end
    end

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step_model(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, phase_o, m_ph);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        mode_i   = 3'b000;
        sel_i    = 1'b0;
        ftw_a_i  = '0;
        ftw_b_i  = '0;
        poff_a_i = '0;
        poff_b_i = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        apply_reset();
        check("R1 in reset", phase_o, 16'h0000);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 after release", phase_o, 16'h0000);
        end
    endtask

    task automatic t_tone();
        ftw_a_i  = 48'h0123_4567_89AB;
        ftw_b_i  = 48'h7777_0000_0000;
        poff_a_i = 14'h0155;
        poff_b_i = 14'h2AAA;
        foreach (mode_i[k]) begin end
        for (int m = 0; m < 8; m++) begin
            if (m == 1 || m == 4) continue;
            mode_i = 3'(m);
            for (int i = 0; i < 4; i++) begin
                sel_i = ~sel_i;
                step_model("R8 sel ignored", 1);
            end
        end
        step_model("R2 steady", 2);
    endtask

    task automatic t_fsk();
        logic [15:0] prev;
        mode_i   = 3'b000;
        sel_i    = 1'b0;
        ftw_a_i  = 48'h0100_0000_0000;
        ftw_b_i  = 48'h0300_0000_0000;
        poff_a_i = 14'h0000;
        step_model("R2 settle", 3);
        mode_i = 3'b001;
        prev = phase_o;
        @(negedge clk);
        check("R3 low step", phase_o - prev, 16'h0100);
        sel_i = 1'b1;
        prev = phase_o;
        @(negedge clk);
        check("R2 latency", phase_o - prev, 16'h0100);
        prev = phase_o;
        @(negedge clk);
        check("R3 high step", phase_o - prev, 16'h0300);
        for (int i = 0; i < 6; i++) begin
            sel_i = (i % 3) == 0;
            step_model("R3 pattern", 1);
        end
    endtask

    task automatic t_bpsk();
        apply_reset();
        rst_n    = 1'b1;
        mode_i   = 3'b100;
        ftw_b_i  = 48'h0555_0000_0000;
        poff_a_i = 14'h0100;
        poff_b_i = 14'h2000;
        sel_i    = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R4 offset a", phase_o, 16'h0400);
        sel_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R4 offset b", phase_o, 16'h8000);
        @(negedge clk);
        check("R6 ftw b ignored in bpsk", phase_o, 16'h8000);
        ftw_a_i = 48'h0002_3456_0000;
        for (int i = 0; i < 6; i++) begin
            sel_i = i[0];
            step_model("R4 pattern", 1);
        end
    endtask

    task automatic t_continuity();
        logic [15:0] prev;
        mode_i   = 3'b001;
        sel_i    = 1'b0;
        ftw_a_i  = 48'h0100_0000_0000;
        ftw_b_i  = 48'h0200_0000_0000;
        poff_a_i = 14'h0011;
        step_model("R5 settle", 3);
        prev = phase_o;
        sel_i = 1'b1;
        @(negedge clk);
        check("R5 no reset on switch", phase_o - prev, 16'h0100);
        prev = phase_o;
        @(negedge clk);
        check("R5 continues", phase_o - prev, 16'h0200);
        prev = phase_o;
        sel_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R5 back to a", phase_o - prev, 16'h0300);
    endtask

    task automatic t_ignored();
        logic [15:0] prev;
        ftw_a_i  = 48'h0040_0000_0000;
        ftw_b_i  = 48'h0ABC_0000_0000;
        poff_a_i = 14'h0000;
        poff_b_i = 14'h1234;
        sel_i    = 1'b1;
        for (int m = 2; m < 4; m++) begin
            mode_i = 3'(m);
            step_model("R7 settle", 2);
            prev = phase_o;
            @(negedge clk);
            check("R6 ftw b ignored", phase_o - prev, 16'h0040);
            check("R7 off b ignored", phase_o, m_ph);
        end
    endtask

    task automatic t_wrap();
        logic [15:0] prev;
        mode_i   = 3'b000;
        ftw_a_i  = 48'hFFFF_0000_0000;
        poff_a_i = 14'h0000;
        step_model("R9 settle", 2);
        for (int i = 0; i < 4; i++) begin
            prev = phase_o;
            @(negedge clk);
            check("R9 wrap", phase_o - prev, 16'hFFFF);
        end
        ftw_a_i = 48'hFFFF_FFFF_FFFF;
        step_model("R9 carry", 5);
    endtask

    task automatic t_off_wrap();
        apply_reset();
        ftw_a_i  = 48'h0008_0000_0000;
        poff_a_i = 14'h3FFF;
        rst_n    = 1'b1;
        @(negedge clk);
        check("R10 first", phase_o, 16'h0000);
        @(negedge clk);
        check("R10 wrap", phase_o, 16'h0004);
        step_model("R10 run", 3);
    endtask

    initial begin
        t_reset();
        t_tone();
        t_fsk();
        t_bpsk();
        t_continuity();
        t_ignored();
        t_wrap();
        t_off_wrap();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule